// File: doc/BRIEF.md
# Backlight Pulse-Width Modulator with Committed Settings

This block drives one pulse-width modulated line for a display backlight. Software reaches it through a plain register port. The port has separate write and read strobes, a byte address and 32-bit data. The waveform has three settings: a clock prescaler that stretches each tick over several input clocks, a period in ticks, and a high time in ticks measured from the start of every cycle.

Software writes the prescaler, the period and the high time into shadow registers first. The running waveform does not see those writes. A rising edge on the commit bit marks the shadow set as pending. The pending set is copied into the active set at the next cycle boundary, so a cycle that has started always completes with the settings it started with. While the output is disabled, a pending set is copied on the next clock.

Setting the enable bit restarts both counters, so the first cycle begins cleanly. Clearing the enable bit holds the output low.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset the output is low and every register reads back as zero.
- R2: Reads return the stored shadow values in their fields, and all other bits read as zero. The fields are: enable in bit 0 at offset 0x00; commit in bit 0 at offset 0x08; prescaler in bits [25:16] at offset 0x10; period in bits [11:0] and high time in bits [28:16] at offset 0x14. An unmapped offset reads as zero.
- R3: While the enable bit (offset 0x00, bit 0) is 0, the output is held low.
- R4: Each tick lasts prescaler+1 input clocks, and one cycle lasts period+1 ticks, so the output repeats every (prescaler+1)×(period+1) clocks.
- R5: Within each cycle the output is high for the first high-time ticks, that is high-time×(prescaler+1) clocks, and low for the rest of the cycle.
- R6: Writes to the prescaler, period or high-time fields leave the running waveform unchanged until a commit.
- R7: A 0-to-1 write of the commit bit (offset 0x08, bit 0) marks the shadow set as pending. While enabled, the pending set becomes active at the first cycle boundary after the commit, and the cycle in progress finishes unchanged. While disabled, the pending set becomes active on the next clock.
- R8: When the high time is greater than or equal to period+1, the enabled output stays high continuously.
- R9: When the high time is 0, the output stays low continuously.
- R10: Setting the enable bit restarts the prescaler and cycle counters. The output goes high in the first clock after the enabling write when the high time is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe; the data is stored on the clock edge |
| reg_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data; zero when reg_rd is low |
| pwm_out | output | 1 | Pulse-width modulated output |

## Verification
The waveform is compared clock by clock against an arithmetic model, under several settings:
- Prescaler 2 with period 4 shows whether the tick and cycle counters nest correctly.
- Prescaler 0 shows that one clock per tick works without a stuck prescaler.
- A high time above the period, and a high time of zero, expose the saturated cases that a wrong comparison would break.

A shadow write without a commit, followed by a commit issued mid-cycle, shows whether the old cycle finishes intact and where the new settings begin. A commit issued while disabled shows that the copy takes effect at once. Re-enabling shows that the counters restart with the output high.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int unsigned OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_ENABLE = 8'h00;
  localparam logic [OFS_W-1:0] OFS_COMMIT = 8'h08;
  localparam logic [OFS_W-1:0] OFS_CTRL0  = 8'h10;
  localparam logic [OFS_W-1:0] OFS_CTRL1  = 8'h14;

  localparam int unsigned PRESC_LSB = 16;
  localparam int unsigned PER_LSB   = 0;
  localparam int unsigned HIGH_LSB  = 16;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PRESC_W = 10,
  parameter int unsigned PER_W   = 12,
  parameter int unsigned HIGH_W  = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [OFS_W-1:0]   addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               en,
  output logic [PRESC_W-1:0] sh_presc,
  output logic [PER_W-1:0]   sh_per,
  output logic [HIGH_W-1:0]  sh_high,
  output logic               commit_rise
);
  logic commit_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata;
  assign commit_rise  = wr && (addr == OFS_COMMIT) && wdata[0] && !commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      commit_q <= 1'b0;
      sh_presc <= '0;
      sh_per   <= '0;
      sh_high  <= '0;
    end else if (wr) begin
      case (addr)
        OFS_ENABLE: en       <= wdata[0];
        OFS_COMMIT: commit_q <= wdata[0];
        OFS_CTRL0:  sh_presc <= wdata[PRESC_LSB +: PRESC_W];
        OFS_CTRL1: begin
          sh_per  <= wdata[PER_LSB +: PER_W];
          sh_high <= wdata[HIGH_LSB +: HIGH_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        OFS_ENABLE: rdata[0] = en;
        OFS_COMMIT: rdata[0] = commit_q;
        OFS_CTRL0:  rdata[PRESC_LSB +: PRESC_W] = sh_presc;
        OFS_CTRL1: begin
          rdata[PER_LSB +: PER_W]   = sh_per;
          rdata[HIGH_LSB +: HIGH_W] = sh_high;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
  parameter int unsigned PRESC_W = 10,
  parameter int unsigned PER_W   = 12,
  parameter int unsigned HIGH_W  = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PRESC_W-1:0] sh_presc,
  input  logic [PER_W-1:0]   sh_per,
  input  logic [HIGH_W-1:0]  sh_high,
  input  logic               commit_rise,
  output logic               pwm_out,
  output logic [PRESC_W-1:0] act_presc,
  output logic [PER_W-1:0]   act_per,
  output logic [HIGH_W-1:0]  act_high,
  output logic [PRESC_W-1:0] tick_cnt,
  output logic [PER_W-1:0]   cyc_cnt,
  output logic               pend,
  output logic               load_act,
  output logic               cycle_end
);
  localparam int unsigned CMP_W = (HIGH_W > PER_W) ? HIGH_W : PER_W;

  logic tick_end;

  function automatic logic is_last_tick(input logic [PRESC_W-1:0] cnt,
                                        input logic [PRESC_W-1:0] lim);
    return cnt == lim;
  endfunction

  function automatic logic is_last_slot(input logic [PER_W-1:0] cnt,
                                        input logic [PER_W-1:0] lim);
    return cnt == lim;
  endfunction

  function automatic logic duty_on(input logic [PER_W-1:0]  slot,
                                   input logic [HIGH_W-1:0] hw);
    logic [CMP_W-1:0] s_ext;
    logic [CMP_W-1:0] h_ext;
    s_ext = CMP_W'(slot);
    h_ext = CMP_W'(hw);
    return s_ext < h_ext;
  endfunction

  assign tick_end  = en && is_last_tick(tick_cnt, act_presc);
  assign cycle_end = tick_end && is_last_slot(cyc_cnt, act_per);
  assign load_act  = pend && (cycle_end || !en);
  assign pwm_out   = en && duty_on(cyc_cnt, act_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (commit_rise) begin
      pend <= 1'b1;
    end else if (load_act) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_presc <= '0;
      act_per   <= '0;
      act_high  <= '0;
    end else if (load_act) begin
      act_presc <= sh_presc;
      act_per   <= sh_per;
      act_high  <= sh_high;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      cyc_cnt  <= '0;
    end else if (!en) begin
      tick_cnt <= '0;
      cyc_cnt  <= '0;
    end else if (tick_end) begin
      tick_cnt <= '0;
      cyc_cnt  <= cycle_end ? '0 : cyc_cnt + 1'b1;
    end else begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PRESC_W = 10,
  parameter int unsigned PER_W   = 12,
  parameter int unsigned HIGH_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  logic               en_q;
  logic [PRESC_W-1:0] sh_presc;
  logic [PER_W-1:0]   sh_per;
  logic [HIGH_W-1:0]  sh_high;
  logic               commit_rise;
  logic [PRESC_W-1:0] act_presc;
  logic [PER_W-1:0]   act_per;
  logic [HIGH_W-1:0]  act_high;
  logic [PRESC_W-1:0] tick_cnt;
  logic [PER_W-1:0]   cyc_cnt;
  logic               pend;
  logic               load_act;
  logic               cycle_end;

  bl_pwm_regs #(
    .DATA_W(DATA_W), .PRESC_W(PRESC_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .en(en_q), .sh_presc(sh_presc),
    .sh_per(sh_per), .sh_high(sh_high), .commit_rise(commit_rise)
  );

  bl_pwm_core #(
    .PRESC_W(PRESC_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
  ) core_i (
    .clk(clk), .rst_n(rst_n), .en(en_q), .sh_presc(sh_presc), .sh_per(sh_per),
    .sh_high(sh_high), .commit_rise(commit_rise), .pwm_out(pwm_out),
    .act_presc(act_presc), .act_per(act_per), .act_high(act_high),
    .tick_cnt(tick_cnt), .cyc_cnt(cyc_cnt), .pend(pend), .load_act(load_act),
    .cycle_end(cycle_end)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int unsigned PRESC_W = 10,
  parameter int unsigned PER_W   = 12,
  parameter int unsigned HIGH_W  = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               pwm_out,
  input logic               commit_rise,
  input logic               pend,
  input logic               load_act,
  input logic [PRESC_W-1:0] act_presc,
  input logic [PER_W-1:0]   act_per,
  input logic [HIGH_W-1:0]  act_high,
  input logic [PRESC_W-1:0] tick_cnt,
  input logic [PER_W-1:0]   cyc_cnt
);
  assert_disabled_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  assert_tick_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt <= act_presc);

  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_act |=> ($stable(act_presc) && $stable(act_per) && $stable(act_high)));

  assert_commit_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_rise |=> pend);

  assert_load_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_act && en) |-> (tick_cnt == act_presc && cyc_cnt == act_per));

  assert_full_duty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (act_high > {1'b0, act_per})) |-> pwm_out);

  assert_zero_high_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_high == '0) |-> !pwm_out);

  assert_enable_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (tick_cnt == '0 && cyc_cnt == '0 && pwm_out == (act_high != '0)));
endmodule

bind bl_pwm_top bl_pwm_chk #(
  .PRESC_W(PRESC_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en_q), .pwm_out(pwm_out),
  .commit_rise(commit_rise), .pend(pend), .load_act(load_act),
  .act_presc(act_presc), .act_per(act_per), .act_high(act_high),
  .tick_cnt(tick_cnt), .cyc_cnt(cyc_cnt)
);

// File: tb/bl_pwm_top_tb_top.sv
`timescale 1ns/1ps
module bl_pwm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int checks = 0;
  int failures = 0;
  int clk_idx = 0;
  int en_idx = 0;
  int a_d = 0, a_p = 0, a_h = 0;
  int b_d = 0, b_p = 0, b_h = 0;
  int nb = 32'h7fffffff;
  bit done = 1'b0;

  bl_pwm_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) clk_idx <= clk_idx + 1;

  function automatic bit model_bit(input int m, input int d, input int p, input int h);
    return ((m / (d + 1)) % (p + 1)) < h;
  endfunction

  function automatic bit exp_out(input int n);
    if (n >= nb) return model_bit(n - nb, b_d, b_p, b_h);
    return model_bit(n, a_d, a_p, a_h);
  endfunction

  task automatic check_val(input string req, input string what,
                           input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic set_shadow(input int d, input int p, input int h);
    wr_reg(8'h10, 32'(d) << 16);
    wr_reg(8'h14, (32'(h) << 16) | 32'(p));
  endtask

  task automatic commit_pulse();
    wr_reg(8'h08, 32'h1);
    wr_reg(8'h08, 32'h0);
  endtask

  task automatic enable_on();
    wr_reg(8'h00, 32'h1);
    en_idx = clk_idx;
  endtask

  // Compares the output with the model for cnt consecutive negedges, from the current one.
  task automatic check_wave(input string req, input int cnt);
    int bad_n = -1;
    bit bad_v = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      if (bad_n < 0 && pwm_out !== exp_out(clk_idx - en_idx)) begin
        bad_n = clk_idx - en_idx;
        bad_v = pwm_out;
      end
      @(negedge clk);
    end
    checks++;
    if (bad_n >= 0) begin
      failures++;
      $display("FAIL %s waveform at n=%0d actual=%0b expected=%0b", req, bad_n,
               bad_v, exp_out(bad_n));
    end
  endtask

  task automatic check_level(input string req, input bit lvl, input int cnt);
    int bad = 0;
    for (int i = 0; i < cnt; i++) begin
      if (pwm_out !== lvl) bad++;
      @(negedge clk);
    end
    check_val(req, "constant level mismatches", bad, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check_val("R1", "output after reset", pwm_out, 0);
    rd_reg(8'h00, d); check_val("R1", "enable reg", d, 0);
    rd_reg(8'h08, d); check_val("R1", "commit reg", d, 0);
    rd_reg(8'h10, d); check_val("R1", "ctrl0 reg", d, 0);
    rd_reg(8'h14, d); check_val("R1", "ctrl1 reg", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr_reg(8'h14, 32'hffff_ffff);
    rd_reg(8'h14, d); check_val("R2", "ctrl1 fields", d, 32'h1fff_0fff);
    wr_reg(8'h10, 32'hffff_ffff);
    rd_reg(8'h10, d); check_val("R2", "ctrl0 field", d, 32'h03ff_0000);
    wr_reg(8'h00, 32'hffff_fffe);
    rd_reg(8'h00, d); check_val("R2", "enable bit clear", d, 0);
    wr_reg(8'h04, 32'hffff_ffff);
    rd_reg(8'h04, d); check_val("R2", "unmapped offset", d, 0);
  endtask

  task automatic t_basic();
    // R4 R5 R10: prescaler 2, period 4, high 2 -> 15-clock cycle, 6 clocks high
    set_shadow(2, 4, 2);
    commit_pulse();
    a_d = 2; a_p = 4; a_h = 2; nb = 32'h7fffffff;
    enable_on();
    check_val("R10", "output right after enable", pwm_out, 1);
    check_wave("R4/R5", 75);
  endtask

  task automatic t_shadow_commit();
    logic [31:0] d;
    int nc;
    int la;
    la = (a_d + 1) * (a_p + 1);
    set_shadow(1, 2, 1);
    b_d = 1; b_p = 2; b_h = 1;
    check_wave("R6", 40);
    rd_reg(8'h14, d); check_val("R6", "shadow readback", d, 32'h0001_0002);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0;
    nc = clk_idx - en_idx;
    nb = (nc / la + 1) * la;
    check_wave("R7", 2);
    wr_reg(8'h08, 32'h0);
    check_wave("R7", 60);
  endtask

  task automatic t_disabled_commit();
    wr_reg(8'h00, 32'h0);
    check_level("R3", 1'b0, 12);
    set_shadow(0, 6, 3);
    commit_pulse();
    a_d = 0; a_p = 6; a_h = 3; nb = 32'h7fffffff;
    check_level("R3", 1'b0, 4);
    enable_on();
    check_wave("R7/R4", 49);
  endtask

  task automatic t_full();
    wr_reg(8'h00, 32'h0);
    set_shadow(0, 3, 9);
    commit_pulse();
    enable_on();
    check_level("R8", 1'b1, 24);
    wr_reg(8'h00, 32'h0);
    set_shadow(1, 3, 4);
    commit_pulse();
    enable_on();
    check_level("R8", 1'b1, 24);
  endtask

  task automatic t_zero();
    wr_reg(8'h00, 32'h0);
    set_shadow(1, 3, 0);
    commit_pulse();
    enable_on();
    check_level("R9", 1'b0, 24);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_basic();
    t_shadow_commit();
    t_disabled_commit();
    t_full();
    t_zero();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule